// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits between an HDLC receive deframer and the receive FIFO. The deframer delivers a byte stream framed by single-cycle start and end strobes. The filter examines the leading address bytes of each frame and decides whether the frame reaches the FIFO. Address bytes are held inside the filter until the decision is made. An accepted frame then has its held bytes replayed, followed by the rest of its bytes. A rejected frame is suppressed up to its end strobe.

The seven address bits of a byte are its bits 7:1. Bit 0 is the address-extension bit and never takes part in a comparison. Single-byte addressing is used when the second-byte enable is low, and two-byte addressing when it is high. A seven-bit all-ones address is an all-call: it overrides both patterns, provided the enable for the deciding byte is set. With recognition turned off, every frame passes straight through.

The interface assumes that any two of the strobes (frame start, byte valid, frame end) are at least three clock cycles apart. This is normal for a bit-serial deframer, and it leaves time to replay the held bytes. Configuration inputs are held stable while a frame is in progress.

Top module: `hdlcRxAddrFilter`

## Requirements
- R1: With `recogEnable` low, `frameAccept` rises the cycle after `frameStart`. Every byte is presented on `storeEn`/`storeData` the cycle after its `byteValid`, and `frameDiscard` never pulses.
- R2: Single-byte mode with `firstEnable` high and `sevenBitMode` low: the frame is accepted when byte bits 7:2 equal `firstPattern[6:1]`. Byte bits 1:0 are ignored.
- R3: With `sevenBitMode` high, the first-byte comparison uses byte bits 7:1 against all of `firstPattern[6:0]`. Byte bit 0 is ignored.
- R4: With `firstEnable` low, the first byte always counts as matching.
- R5: Two-byte mode (`secondEnable` high) accepts the frame when the first byte matches and byte-2 bits 7:1 equal `secondPattern`. On acceptance, byte 1 is stored the cycle after byte 2's strobe and byte 2 is stored one cycle later. Later bytes are stored the cycle after their strobes.
- R6: In single-byte mode, a first byte whose bits 7:1 are all ones is accepted when `firstEnable` is high, whatever the first pattern.
- R7: In two-byte mode, a second byte whose bits 7:1 are all ones accepts the frame, whatever either pattern holds.
- R8: A frame that fails the comparison stores no byte. `frameDiscard` pulses for one cycle, the cycle after the deciding byte's strobe, and `frameAccept` stays low.
- R9: When recognition is on and `frameEnd` arrives before all required address bytes, nothing is stored and `frameDiscard` pulses the cycle after `frameEnd`.
- R10: `frameAccept` falls the cycle after `frameEnd`. Bytes that arrive outside a frame are neither stored nor counted as discards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Single-cycle start-of-frame strobe |
| frameEnd | input | 1 | Single-cycle end-of-frame strobe |
| byteValid | input | 1 | `byteIn` carries a frame byte |
| byteIn | input | 8 | Received byte |
| recogEnable | input | 1 | Address recognition on |
| sevenBitMode | input | 1 | First-byte comparison is seven bits wide |
| firstEnable | input | 1 | First-byte pattern takes part in the comparison |
| secondEnable | input | 1 | Two-byte addressing with second-byte pattern |
| firstPattern | input | 7 | First-byte pattern, bit 6 aligned to byte bit 7 |
| secondPattern | input | 7 | Second-byte pattern, bit 6 aligned to byte bit 7 |
| storeEn | output | 1 | Write strobe toward the receive FIFO |
| storeData | output | 8 | Byte to write |
| frameAccept | output | 1 | Current frame has been accepted |
| frameDiscard | output | 1 | One-cycle pulse when a frame is dropped |

## Verification
The hardest case to reach is the two-byte replay. Byte 1 must come out of its holding register while byte 2 is being captured, and byte 2 must follow one cycle later, with the order and timing exact. It also has to interact correctly with all-call overrides and with the six- versus seven-bit choice on byte 1. The bench sweeps every 7-bit value of each address byte in turn, with the other byte held at a matching value, under all sixteen settings of the four enable and mode bits. It checks each stored byte's value and cycle against a model computed from the requirements. Short directed frames cover truncation and bytes outside a frame.

// File: rtl/hdlcAddrPkg.sv
package hdlcAddrPkg;

  typedef enum logic [1:0] {
    SEL_IN = 2'd0,
    SEL_H0 = 2'd1,
    SEL_H1 = 2'd2
  } outSel_t;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ADDR1 = 3'd1,
    S_ADDR2 = 3'd2,
    S_PASS  = 3'd3,
    S_DROP  = 3'd4
  } filtState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    loadHold0;
    logic    loadHold1;
    logic    outValid;
    outSel_t outSel;
  } dpCtl_t;

endpackage

// File: rtl/hdlcAddrDatapath.sv
module hdlcAddrDatapath
  import hdlcAddrPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] byteIn,
  input  dpCtl_t            ctl,
  input  logic              sevenBitMode,
  input  logic              firstEnable,
  input  logic [ADDR_W-1:0] firstPattern,
  input  logic [ADDR_W-1:0] secondPattern,
  output logic              firstOk,
  output logic              secondOk,
  output logic              allOnes,
  output logic              storeEn,
  output logic [DATA_W-1:0] storeData
);
  localparam int LO_BIT = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] addrIn;
  logic [DATA_W-1:0] hold0Q, hold1Q, outMux;

  assign addrIn = byteIn[DATA_W-1:LO_BIT];

  // the lowest pattern bit only counts in seven-bit mode
  always_comb begin
    if (!firstEnable)
      firstOk = 1'b1;
    else if (sevenBitMode)
      firstOk = (addrIn == firstPattern);
    else
      firstOk = (addrIn[ADDR_W-1:1] == firstPattern[ADDR_W-1:1]);
  end

  assign secondOk = (addrIn == secondPattern);
  assign allOnes  = &addrIn;

  always_comb begin
    case (ctl.outSel)
      SEL_H0:  outMux = hold0Q;
      SEL_H1:  outMux = hold1Q;
      default: outMux = byteIn;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hold0Q    <= '0;
      hold1Q    <= '0;
      storeEn   <= 1'b0;
      storeData <= '0;
    end else begin
      if (ctl.loadHold0) hold0Q <= byteIn;
      if (ctl.loadHold1) hold1Q <= byteIn;
      storeEn <= ctl.outValid;
      if (ctl.outValid) storeData <= outMux;
    end
  end

endmodule

// File: rtl/hdlcAddrCtrl.sv
module hdlcAddrCtrl
  import hdlcAddrPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   frameStart,
  input  logic   frameEnd,
  input  logic   byteValid,
  input  logic   recogEnable,
  input  logic   firstEnable,
  input  logic   secondEnable,
  input  logic   firstOk,
  input  logic   secondOk,
  input  logic   allOnes,
  output dpCtl_t ctl,
  output logic   frameAccept,
  output logic   frameDiscard
);
  filtState_t stateQ, stateD;
  logic acceptQ, acceptD, discardQ, discardD;
  logic replayQ, replayD, firstOkQ, firstOkD;

  always_comb begin
    ctl      = '0;
    stateD   = stateQ;
    acceptD  = acceptQ;
    discardD = 1'b0;
    replayD  = 1'b0;
    firstOkD = firstOkQ;
    if (replayQ) begin
      ctl.outValid = 1'b1;
      ctl.outSel   = SEL_H1;
    end
    if (frameStart) begin
      stateD  = recogEnable ? S_ADDR1 : S_PASS;
      acceptD = !recogEnable;
    end else if (frameEnd) begin
      if (stateQ == S_ADDR1 || stateQ == S_ADDR2) discardD = 1'b1;
      stateD  = S_IDLE;
      acceptD = 1'b0;
    end else if (byteValid) begin
      case (stateQ)
        S_ADDR1: begin
          if (secondEnable) begin
            ctl.loadHold0 = 1'b1;
            firstOkD      = firstOk;
            stateD        = S_ADDR2;
          end else if (firstOk || (firstEnable && allOnes)) begin
            ctl.outValid = 1'b1;
            ctl.outSel   = SEL_IN;
            stateD       = S_PASS;
            acceptD      = 1'b1;
          end else begin
            stateD   = S_DROP;
            discardD = 1'b1;
          end
        end
        S_ADDR2: begin
          if ((firstOkQ && secondOk) || allOnes) begin
            ctl.loadHold1 = 1'b1;
            ctl.outValid  = 1'b1;
            ctl.outSel    = SEL_H0;
            replayD       = 1'b1;
            stateD        = S_PASS;
            acceptD       = 1'b1;
          end else begin
            stateD   = S_DROP;
            discardD = 1'b1;
          end
        end
        S_PASS: begin
          ctl.outValid = 1'b1;
          ctl.outSel   = SEL_IN;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= S_IDLE;
      acceptQ  <= 1'b0;
      discardQ <= 1'b0;
      replayQ  <= 1'b0;
      firstOkQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      acceptQ  <= acceptD;
      discardQ <= discardD;
      replayQ  <= replayD;
      firstOkQ <= firstOkD;
    end
  end

  assign frameAccept  = acceptQ;
  assign frameDiscard = discardQ;

  // a dropped frame never writes
  assert_no_store_in_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_DROP) |-> !ctl.outValid);

  // replay of the second held byte only happens inside an accepted frame
  assert_replay_in_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    replayQ |-> (stateQ == S_PASS && acceptQ));

  assert_accept_discard_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(acceptQ && discardQ));

  assert_accept_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && !frameStart) |=> !frameAccept);

  assert_bypass_accepts_R1: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && !recogEnable) |=> (frameAccept && !frameDiscard));

endmodule

// File: rtl/hdlcRxAddrFilter.sv
module hdlcRxAddrFilter
  import hdlcAddrPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              frameEnd,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteIn,
  input  logic              recogEnable,
  input  logic              sevenBitMode,
  input  logic              firstEnable,
  input  logic              secondEnable,
  input  logic [ADDR_W-1:0] firstPattern,
  input  logic [ADDR_W-1:0] secondPattern,
  output logic              storeEn,
  output logic [DATA_W-1:0] storeData,
  output logic              frameAccept,
  output logic              frameDiscard
);
  dpCtl_t ctl;
  logic firstOk, secondOk, allOnes;

  hdlcAddrCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .frameStart   (frameStart),
    .frameEnd     (frameEnd),
    .byteValid    (byteValid),
    .recogEnable  (recogEnable),
    .firstEnable  (firstEnable),
    .secondEnable (secondEnable),
    .firstOk      (firstOk),
    .secondOk     (secondOk),
    .allOnes      (allOnes),
    .ctl          (ctl),
    .frameAccept  (frameAccept),
    .frameDiscard (frameDiscard)
  );

  hdlcAddrDatapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .byteIn        (byteIn),
    .ctl           (ctl),
    .sevenBitMode  (sevenBitMode),
    .firstEnable   (firstEnable),
    .firstPattern  (firstPattern),
    .secondPattern (secondPattern),
    .firstOk       (firstOk),
    .secondOk      (secondOk),
    .allOnes       (allOnes),
    .storeEn       (storeEn),
    .storeData     (storeData)
  );

endmodule

// File: tb/sim_hdlcRxAddrFilter.sv
module sim_hdlcRxAddrFilter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rstN = 1'b0;
  logic frameStart = 0, frameEnd = 0, byteValid = 0;
  logic [7:0] byteIn = '0;
  logic recogEnable = 0, sevenBitMode = 0, firstEnable = 0, secondEnable = 0;
  logic [6:0] firstPattern = '0, secondPattern = '0;
  logic storeEn, frameAccept, frameDiscard;
  logic [7:0] storeData;

  hdlcRxAddrFilter u0 (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameEnd(frameEnd),
    .byteValid(byteValid), .byteIn(byteIn), .recogEnable(recogEnable),
    .sevenBitMode(sevenBitMode), .firstEnable(firstEnable),
    .secondEnable(secondEnable), .firstPattern(firstPattern),
    .secondPattern(secondPattern), .storeEn(storeEn), .storeData(storeData),
    .frameAccept(frameAccept), .frameDiscard(frameDiscard)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  logic [7:0] gotData [8];
  int gotCyc [8];
  int gotN = 0, discN = 0, discCyc = 0;
  bit finished = 0;

  // output monitor, a quarter period after each edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (storeEn) begin
      if (gotN < 8) begin
        gotData[gotN] = storeData;
        gotCyc[gotN]  = cyc;
      end
      gotN++;
    end
    if (frameDiscard) begin
      discN++;
      discCyc = cyc;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // kind: 0 start, 1 byte, 2 end; ev returns the cycle of the sampling edge
  task automatic strobe(input int kind, input logic [7:0] d, output int ev);
    @(negedge clk);
    frameStart = (kind == 0);
    byteValid  = (kind == 1);
    frameEnd   = (kind == 2);
    byteIn     = d;
    @(negedge clk);
    ev = cyc;
    frameStart = 0; byteValid = 0; frameEnd = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic setCfg(input logic [3:0] c);
    @(negedge clk);
    recogEnable  = c[0];
    firstEnable  = c[1];
    secondEnable = c[2];
    sevenBitMode = c[3];
    gotN = 0; discN = 0;
  endtask

  task automatic runFrame(input logic [7:0] a1, input logic [7:0] a2,
                          input logic [7:0] d1, input logic [7:0] d2);
    int evS, ev1, ev2, ev3, ev4, evE, expN;
    bit m1, acc;
    string tag;
    logic [7:0] expD [4];
    int expC [4];
    m1 = !firstEnable ||
         (sevenBitMode ? (a1[7:1] == firstPattern) : (a1[7:2] == firstPattern[6:1]));
    if (!recogEnable) begin
      acc = 1; tag = "R1";
    end else if (!secondEnable) begin
      acc = m1 || (firstEnable && (&a1[7:1]));
      tag = (firstEnable && (&a1[7:1])) ? "R6" : (!firstEnable ? "R4" : (sevenBitMode ? "R3" : "R2"));
    end else begin
      acc = (m1 && (a2[7:1] == secondPattern)) || (&a2[7:1]);
      tag = (&a2[7:1]) ? "R7" : "R5";
    end
    @(negedge clk); gotN = 0; discN = 0;
    strobe(0, 8'h00, evS);
    strobe(1, a1, ev1);
    strobe(1, a2, ev2);
    strobe(1, d1, ev3);
    strobe(1, d2, ev4);
    check(frameAccept == acc, tag, "frameAccept", frameAccept, acc);
    strobe(2, 8'h00, evE);
    check(frameAccept == 0, "R10", "frameAccept after end", frameAccept, 0);
    expD[0] = a1; expD[1] = a2; expD[2] = d1; expD[3] = d2;
    expC[0] = ev1; expC[1] = ev2; expC[2] = ev3; expC[3] = ev4;
    if (recogEnable && secondEnable) begin
      expC[0] = ev2; expC[1] = ev2 + 1;
    end
    expN = acc ? 4 : 0;
    check(gotN == expN, acc ? tag : "R8", "stored count", gotN, expN);
    if (acc && gotN == 4) begin
      for (int i = 0; i < 4; i++) begin
        check(gotData[i] == expD[i], tag, "stored byte", gotData[i], expD[i]);
        check(gotCyc[i] == expC[i], tag, "store cycle", gotCyc[i], expC[i]);
      end
    end
    check(discN == (acc ? 0 : 1), acc ? tag : "R8", "discard count", discN, acc ? 0 : 1);
    if (!acc && discN == 1)
      check(discCyc == (secondEnable ? ev2 : ev1), "R8", "discard cycle",
            discCyc, secondEnable ? ev2 : ev1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int ev, evE;
    firstPattern  = 7'h2D;
    secondPattern = 7'h4A;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!storeEn && !frameAccept && !frameDiscard, "R10", "reset outputs",
          {storeEn, frameAccept, frameDiscard}, 0);

    // sweeps over all mode and enable settings
    for (int c = 0; c < 16; c++) begin
      setCfg(c[3:0]);
      for (int v = 0; v < 128; v++)
        runFrame({v[6:0], ~v[0]}, {secondPattern, v[1]}, 8'hA5, 8'h3C);
      for (int v = 0; v < 128; v++)
        runFrame({firstPattern, v[2]}, {v[6:0], v[0]}, 8'h5A, 8'hC3);
    end

    // R9: truncated two-byte address
    setCfg(4'b0111);
    strobe(0, 8'h00, ev);
    strobe(1, {firstPattern, 1'b0}, ev);
    strobe(2, 8'h00, evE);
    check(gotN == 0, "R9", "stored on truncation", gotN, 0);
    check(discN == 1 && discCyc == evE, "R9", "discard after end", discCyc, evE);

    // R9: frame with no address byte, single-byte mode
    setCfg(4'b0011);
    strobe(0, 8'h00, ev);
    strobe(2, 8'h00, evE);
    check(gotN == 0 && discN == 1, "R9", "empty frame discards", discN, 1);

    // R1: empty frame with recognition off is not discarded
    setCfg(4'b0000);
    strobe(0, 8'h00, ev);
    strobe(2, 8'h00, evE);
    check(discN == 0, "R1", "no discard when bypassed", discN, 0);

    // R10: bytes outside any frame are ignored
    setCfg(4'b0000);
    strobe(1, 8'h77, ev);
    strobe(1, 8'h11, ev);
    check(gotN == 0, "R10", "stores outside frame", gotN, 0);
    check(discN == 0 && !frameAccept, "R10", "discards outside frame", discN, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule